// File: doc/BRIEF.md
# Rotating Register File Renamer

A register file for software-pipelined loops. Logical specifiers below a fixed boundary address physical registers directly. Specifiers in the upper region are offset by a rotating base and wrapped within that region, so every loop iteration sees a fresh set of physical registers without any code being duplicated.

A loop-close strobe steps the base down by one. A value produced under logical specifier Rk is then consumed under Rk+1 in the next iteration, so the distance between a producer and its consumer is carried by the specifier numbers. A separate clear input returns the base to zero between loops. Reads are combinational. Writes, base steps and base clears take effect on the rising clock edge.

By default the block has 16 logical specifiers of 4 bits each. Specifiers 0..7 form the fixed region and 8..15 form the rotating region. The data width is 32 bits, with two read ports and one write port.

Top module: `rot_regfile`

## Requirements
- R1: Driving rst_ni low clears every register and sets the base to 0 at once, so every specifier then reads 0.
- R2: A specifier in 0..7 always addresses the physical register with the same number, whatever the base.
- R3: A specifier s in 8..15 addresses physical register 8 + ((s - 8 + base) mod 8). A value written under Rk is read under Rk+1 after one loop close.
- R4: The rotating offset wraps inside the region: a value written as R15 is read as R8 after one loop close.
- R5: Each loop_close_i cycle decrements the base by one, and a base of 0 steps to 7. After eight closes the mapping is back where it started.
- R6: A read of the same physical register that is written in the same cycle returns the new write data.
- R7: In a cycle with both a write and loop_close_i high, the write and all reads use the base from before the step.
- R8: base_clr_i sets the base to 0 on the next edge, takes priority over loop_close_i, and leaves the register contents unchanged.
- R9: The read ports decode independently, and two ports given the same specifier return the same data.
- R10: While wr_en_i is low, wr_spec_i and wr_data_i have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| loop_close_i | input | 1 | Step the rotating base down by one |
| base_clr_i | input | 1 | Return the rotating base to 0 |
| wr_en_i | input | N_WR | Write enable per write port |
| wr_spec_i | input | N_WR x 4 | Logical write specifier per port |
| wr_data_i | input | N_WR x 32 | Write data per port |
| rd_spec_i | input | N_RD x 4 | Logical read specifier per port |
| rd_data_o | output | N_RD x 32 | Read data per port |

## Verification
Read data depends on the current specifiers, the base and the storage contents through logic alone, so a read result is due in the same cycle as its specifier. The bench drives inputs just after a falling edge and samples 1 ns later, before the next rising edge. A write, a loop close or a base clear shows up only after the next rising edge, so each of their effects is checked in the following cycle's sampling window. Asynchronous reset is the exception: its effect is checked 1 ns after rst_ni falls, with no clock edge in between.

// File: rtl/rot_rf_pkg.sv
package rot_rf_pkg;

  typedef enum logic [1:0] {
    BASE_HOLD = 2'd0,
    BASE_STEP = 2'd1,
    BASE_CLR  = 2'd2
  } base_op_e;

  // clear outranks step
  function automatic base_op_e base_op_sel(input logic clr, input logic step);
    if (clr)  return BASE_CLR;
    if (step) return BASE_STEP;
    return BASE_HOLD;
  endfunction

endpackage

// File: rtl/rrf_base_ctr.sv
module rrf_base_ctr
  import rot_rf_pkg::*;
#(
  parameter int NREG_ROT = 8,
  parameter int ROT_W    = $clog2(NREG_ROT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  base_op_e         op_i,
  output logic [ROT_W-1:0] base_o
);

  localparam logic [ROT_W-1:0] LAST = ROT_W'(NREG_ROT - 1);
  localparam logic [ROT_W-1:0] ONE  = ROT_W'(1);

  logic [ROT_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else begin
      unique case (op_i)
        BASE_CLR:  base_q <= '0;
        BASE_STEP: base_q <= (base_q == '0) ? LAST : base_q - ONE;
        default:   base_q <= base_q;
      endcase
    end
  end

  assign base_o = base_q;

endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
  parameter int NREG_FIX = 8,
  parameter int NREG_ROT = 8,
  parameter int SPEC_W   = 4,
  parameter int ROT_W    = 3
) (
  input  logic [SPEC_W-1:0] spec_i,
  input  logic [ROT_W-1:0]  base_i,
  output logic [SPEC_W-1:0] phys_o
);

  localparam logic [SPEC_W:0] FIX_L = (SPEC_W+1)'(NREG_FIX);
  localparam logic [SPEC_W:0] ROT_L = (SPEC_W+1)'(NREG_ROT);
  localparam logic [SPEC_W:0] END_L = (SPEC_W+1)'(NREG_FIX + NREG_ROT);

  logic [SPEC_W:0] spec_x;
  logic [SPEC_W:0] rel;
  logic [SPEC_W:0] tgt;

  always_comb begin
    spec_x = {1'b0, spec_i};
    // both operands are below ROT_L, so one subtraction wraps the sum
    rel = spec_x - FIX_L + (SPEC_W+1)'(base_i);
    if (rel >= ROT_L) rel = rel - ROT_L;
    tgt = rel + FIX_L;
    if (spec_x >= FIX_L && spec_x < END_L) phys_o = tgt[SPEC_W-1:0];
    else                                   phys_o = spec_i;
  end

endmodule

// File: rtl/rrf_store.sv
module rrf_store #(
  parameter int DATA_W = 32,
  parameter int SPEC_W = 4,
  parameter int N_RD   = 2,
  parameter int N_WR   = 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_WR-1:0]                wr_en_i,
  input  logic [N_WR-1:0][SPEC_W-1:0]    wr_phys_i,
  input  logic [N_WR-1:0][DATA_W-1:0]    wr_data_i,
  input  logic [N_RD-1:0][SPEC_W-1:0]    rd_phys_i,
  output logic [N_RD-1:0][DATA_W-1:0]    rd_data_o
);

  localparam int DEPTH = 1 << SPEC_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // a higher-numbered write port wins on a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int w = 0; w < N_WR; w++) begin
        if (wr_en_i[w]) mem_q[wr_phys_i[w]] <= wr_data_i[w];
      end
    end
  end

  // write-first: same-cycle writes bypass the array
  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    always_comb begin
      rd_data_o[r] = mem_q[rd_phys_i[r]];
      for (int w = 0; w < N_WR; w++) begin
        if (wr_en_i[w] && wr_phys_i[w] == rd_phys_i[r]) rd_data_o[r] = wr_data_i[w];
      end
    end
  end

endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
  import rot_rf_pkg::*;
#(
  parameter  int DATA_W   = 32,
  parameter  int NREG_FIX = 8,
  parameter  int NREG_ROT = 8,
  parameter  int N_RD     = 2,
  parameter  int N_WR     = 1,
  localparam int SPEC_W   = $clog2(NREG_FIX + NREG_ROT),
  localparam int ROT_W    = $clog2(NREG_ROT)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        loop_close_i,
  input  logic                        base_clr_i,
  input  logic [N_WR-1:0]             wr_en_i,
  input  logic [N_WR-1:0][SPEC_W-1:0] wr_spec_i,
  input  logic [N_WR-1:0][DATA_W-1:0] wr_data_i,
  input  logic [N_RD-1:0][SPEC_W-1:0] rd_spec_i,
  output logic [N_RD-1:0][DATA_W-1:0] rd_data_o
);

  base_op_e                    base_op;
  logic [ROT_W-1:0]            base_q;
  logic [N_RD-1:0][SPEC_W-1:0] rd_phys;
  logic [N_WR-1:0][SPEC_W-1:0] wr_phys;

  assign base_op = base_op_sel(base_clr_i, loop_close_i);

  rrf_base_ctr #(
    .NREG_ROT (NREG_ROT),
    .ROT_W    (ROT_W)
  ) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (base_op),
    .base_o (base_q)
  );

  // every mapper sees the base from before this cycle's step
  for (genvar r = 0; r < N_RD; r++) begin : g_rd_map
    rrf_map #(
      .NREG_FIX (NREG_FIX),
      .NREG_ROT (NREG_ROT),
      .SPEC_W   (SPEC_W),
      .ROT_W    (ROT_W)
    ) u_map (
      .spec_i (rd_spec_i[r]),
      .base_i (base_q),
      .phys_o (rd_phys[r])
    );
  end

  for (genvar w = 0; w < N_WR; w++) begin : g_wr_map
    rrf_map #(
      .NREG_FIX (NREG_FIX),
      .NREG_ROT (NREG_ROT),
      .SPEC_W   (SPEC_W),
      .ROT_W    (ROT_W)
    ) u_map (
      .spec_i (wr_spec_i[w]),
      .base_i (base_q),
      .phys_o (wr_phys[w])
    );
  end

  rrf_store #(
    .DATA_W (DATA_W),
    .SPEC_W (SPEC_W),
    .N_RD   (N_RD),
    .N_WR   (N_WR)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_phys_i (wr_phys),
    .wr_data_i (wr_data_i),
    .rd_phys_i (rd_phys),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/rot_regfile_chk.sv
module rot_regfile_chk #(
  parameter  int DATA_W   = 32,
  parameter  int NREG_FIX = 8,
  parameter  int NREG_ROT = 8,
  parameter  int N_RD     = 2,
  parameter  int N_WR     = 1,
  localparam int SPEC_W   = $clog2(NREG_FIX + NREG_ROT),
  localparam int ROT_W    = $clog2(NREG_ROT)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        loop_close_i,
  input logic                        base_clr_i,
  input logic [ROT_W-1:0]            base_q,
  input logic [N_WR-1:0]             wr_en_i,
  input logic [N_WR-1:0][SPEC_W-1:0] wr_phys,
  input logic [N_WR-1:0][DATA_W-1:0] wr_data_i,
  input logic [N_RD-1:0][SPEC_W-1:0] rd_spec_i,
  input logic [N_RD-1:0][SPEC_W-1:0] rd_phys,
  input logic [N_RD-1:0][DATA_W-1:0] rd_data_o
);

  localparam logic [ROT_W-1:0] LAST  = ROT_W'(NREG_ROT - 1);
  localparam logic [SPEC_W:0]  FIX_L = (SPEC_W+1)'(NREG_FIX);
  localparam int               WT    = N_WR - 1;

  assert_base_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_close_i && !base_clr_i) |=>
      base_q == (($past(base_q) == '0) ? LAST : $past(base_q) - ROT_W'(1)));

  assert_base_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_clr_i |=> base_q == '0);

  assert_base_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_close_i && !base_clr_i) |=> $stable(base_q));

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assert_fix_map_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, rd_spec_i[r]} < FIX_L) |-> rd_phys[r] == rd_spec_i[r]);

    assert_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i[WT] && wr_phys[WT] == rd_phys[r]) |-> rd_data_o[r] == wr_data_i[WT]);

    assert_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[WT] |=>
        ((wr_en_i == '0 && rd_phys[r] == $past(wr_phys[WT])) ->
          rd_data_o[r] == $past(wr_data_i[WT])));
  end

endmodule

bind rot_regfile rot_regfile_chk #(
  .DATA_W   (DATA_W),
  .NREG_FIX (NREG_FIX),
  .NREG_ROT (NREG_ROT),
  .N_RD     (N_RD),
  .N_WR     (N_WR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .loop_close_i (loop_close_i),
  .base_clr_i   (base_clr_i),
  .base_q       (base_q),
  .wr_en_i      (wr_en_i),
  .wr_phys      (wr_phys),
  .wr_data_i    (wr_data_i),
  .rd_spec_i    (rd_spec_i),
  .rd_phys      (rd_phys),
  .rd_data_o    (rd_data_o)
);

// File: tb/tb_rot_regfile.sv
module tb_rot_regfile;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              loop_close_i = 1'b0;
  logic              base_clr_i = 1'b0;
  logic [0:0]        wr_en_i = '0;
  logic [0:0][3:0]   wr_spec_i = '0;
  logic [0:0][31:0]  wr_data_i = '0;
  logic [1:0][3:0]   rd_spec_i = '0;
  logic [1:0][31:0]  rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  rot_regfile dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .loop_close_i (loop_close_i),
    .base_clr_i   (base_clr_i),
    .wr_en_i      (wr_en_i),
    .wr_spec_i    (wr_spec_i),
    .wr_data_i    (wr_data_i),
    .rd_spec_i    (rd_spec_i),
    .rd_data_o    (rd_data_o)
  );

  typedef struct packed {
    logic        lc;
    logic        we;
    logic [3:0]  ws;
    logic [31:0] wd;
    logic [3:0]  r0;
    logic [31:0] e0;
    logic [23:0] t0;
    logic [3:0]  r1;
    logic [31:0] e1;
    logic [23:0] t1;
  } vec_t;

  localparam logic [31:0] VA = 32'hA0A0_0001;
  localparam logic [31:0] VB = 32'hB3B3_0003;
  localparam logic [31:0] VC = 32'hC7C7_0007;

  // base before each row: 0,7,7,6,6,6
  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b1, 4'd8,  VA,            4'd8,  VA, "R6",  4'd3,  32'd0, "R1"},
    '{1'b0, 1'b1, 4'd3,  VB,            4'd9,  VA, "R7",  4'd8,  32'd0, "R3"},
    '{1'b1, 1'b1, 4'd15, VC,            4'd3,  VB, "R2",  4'd9,  VA,    "R3"},
    '{1'b0, 1'b0, 4'd0,  32'd0,         4'd8,  VC, "R4",  4'd10, VA,    "R3"},
    '{1'b0, 1'b0, 4'd10, 32'hDEAD_BEEF, 4'd3,  VB, "R2",  4'd10, VA,    "R10"},
    '{1'b0, 1'b0, 4'd0,  32'd0,         4'd10, VA, "R10", 4'd0,  32'd0, "R1"}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    loop_close_i = 1'b0;
    base_clr_i   = 1'b0;
    wr_en_i      = '0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, every specifier reads zero
    #1;
    for (int s = 0; s < 16; s++) begin
      rd_spec_i[0] = 4'(s);
      #0.1;
      chk("R1", rd_data_o[0], 32'd0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      loop_close_i = VECS[i].lc;
      wr_en_i[0]   = VECS[i].we;
      wr_spec_i[0] = VECS[i].ws;
      wr_data_i[0] = VECS[i].wd;
      rd_spec_i[0] = VECS[i].r0;
      rd_spec_i[1] = VECS[i].r1;
      #1;
      chk(string'(VECS[i].t0), rd_data_o[0], VECS[i].e0);
      chk(string'(VECS[i].t1), rd_data_o[1], VECS[i].e1);
    end

    // R8: clear together with close, base becomes 0, data kept
    @(negedge clk_i);
    idle();
    base_clr_i   = 1'b1;
    loop_close_i = 1'b1;
    @(negedge clk_i);
    idle();
    rd_spec_i[0] = 4'd8;
    rd_spec_i[1] = 4'd8;
    #1;
    chk("R8", rd_data_o[0], VA);
    chk("R9", rd_data_o[1], VA);
    rd_spec_i[0] = 4'd14;
    #1;
    chk("R8", rd_data_o[0], VC);

    // R5: eight closes walk the value around the region and back
    @(negedge clk_i);
    wr_en_i[0]   = 1'b1;
    wr_spec_i[0] = 4'd12;
    wr_data_i[0] = 32'h0000_0055;
    @(negedge clk_i);
    idle();
    for (int i = 1; i <= 8; i++) begin
      loop_close_i = 1'b1;
      @(negedge clk_i);
      loop_close_i = 1'b0;
      rd_spec_i[0] = 4'(8 + ((4 + i) % 8));
      #1;
      chk("R5", rd_data_o[0], 32'h0000_0055);
    end

    // R1: asynchronous reset clears without a clock edge
    @(negedge clk_i);
    rst_ni = 1'b0;
    rd_spec_i[0] = 4'd12;
    rd_spec_i[1] = 4'd3;
    #1;
    chk("R1", rd_data_o[0], 32'd0);
    chk("R1", rd_data_o[1], 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule